// File: doc/BRIEF.md
# Real-Time Clock Setup and Polling Sequencer

This block drives a serial real-time-clock chip through a separate three-wire transfer engine. After reset it sends a fixed series of register writes. The series clears write protection, loads a starting date and time, and sets up trickle charging. It then turns write protection back on. From that point it reads the clock registers in an endless loop.

The returned BCD bytes are gathered into three 24-bit display words:
- hours/minutes/seconds;
- year/month/date;
- weekday, zero-extended to 24 bits.

Two button inputs, already debounced, pick which word goes to a six-digit display driver. The sequencer hands one transfer at a time to the engine over a request/done handshake. It waits for done before it issues the next transfer.

Top module: `rtc_init_poll_seq`

## Requirements
- R1: The first request after reset is a write (`xfer_write`=1) of 0x00 to address 0x8E.
- R2: The next seven requests are writes of the start values to seconds 0x80, minutes 0x82, hours 0x84, date 0x86, month 0x88, weekday 0x8A and year 0x8C, in that order. With default parameters the values are 0x30, 0x11, 0x08, 0x21, 0x03, 0x03 and 0x17. Every write address is even.
- R3: After the year write, one write of the trickle value (default 0xA7) goes to address 0x90.
- R4: Write protection is restored by writing 0x80 to 0x8E before any read is requested.
- R5: Reads then repeat forever in the order 0x81, 0x83, 0x85, 0x87, 0x89, 0x8D, 0x8B, with `xfer_write`=0. Every read address is odd.
- R6: `xfer_req` is a one-cycle pulse. No new request appears until `xfer_done` has been seen. Address, data and direction stay constant while the transfer is pending.
- R7: The time word is {hours, minutes, seconds with bit 7 cleared}, with hours in bits 23:16. It changes only in the cycle after the hours read (0x85) completes. Until then it keeps its old value while seconds and minutes are being read.
- R8: The date word is {year, month, date}, with year in bits 23:16. It changes only in the cycle after the year read (0x8D) completes.
- R9: The weekday word is 16 zero bits above the weekday byte. It changes only in the cycle after the weekday read (0x8B) completes.
- R10: Key selection, with key[0] as the weekday button and key[1] as the date button:
  - key=01 or 11 outputs the weekday word;
  - key=10 outputs the date word;
  - key=00 outputs the time word.
- R11: While reset is held, `xfer_req` is 0 and `disp_word` is 0. A reset in the middle of the sequence starts it again from the R1 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_req | output | 1 | One-cycle transfer request to the engine |
| xfer_write | output | 1 | 1 = write transfer, 0 = read |
| xfer_addr | output | 8 | Register address / command byte |
| xfer_wdata | output | 8 | Write data byte |
| xfer_done | input | 1 | One-cycle completion pulse from the engine |
| xfer_rdata | input | 8 | Read byte, valid with `xfer_done` |
| key | input | 2 | Debounced display-select buttons |
| disp_word | output | 24 | Selected display word (six BCD digits) |

## Verification
The assertions assume the engine raises `xfer_done` only while a transfer is pending and never in the same cycle as the request. They also assume that reset is held for at least two clock cycles.

The bench acts as the engine and keeps within these assumptions. It waits at least one cycle after each request before it pulses done, and it varies that wait from one to four cycles. Read data sweeps a range of BCD values, and the seconds byte has its halt bit set on alternate loops. All four key combinations are checked after every completed read.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;
   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned WORD_W     = 3 * BYTE_W;
   localparam int unsigned N_WR_STEPS = 10;
   localparam int unsigned N_RD_STEPS = 7;
   localparam int unsigned N_STEPS    = N_WR_STEPS + N_RD_STEPS;
   localparam int unsigned STEP_W     = $clog2(N_STEPS);
   localparam int unsigned IDX_W      = 3;

   // register indices (address bits 3:1 of the clock registers)
   localparam logic [IDX_W-1:0] IX_SEC  = 3'd0;
   localparam logic [IDX_W-1:0] IX_MIN  = 3'd1;
   localparam logic [IDX_W-1:0] IX_HOUR = 3'd2;
   localparam logic [IDX_W-1:0] IX_DATE = 3'd3;
   localparam logic [IDX_W-1:0] IX_MON  = 3'd4;
   localparam logic [IDX_W-1:0] IX_WDAY = 3'd5;
   localparam logic [IDX_W-1:0] IX_YEAR = 3'd6;

   localparam logic [BYTE_W-1:0] CTRL_ADDR    = 8'h8E;
   localparam logic [BYTE_W-1:0] TRICKLE_ADDR = 8'h90;
   localparam logic [BYTE_W-1:0] PROTECT_OFF  = 8'h00;
   localparam logic [BYTE_W-1:0] PROTECT_ON   = 8'h80;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ISSUE = 2'd1,
      SQ_WAIT  = 2'd2
   } sq_state_t;
endpackage

// File: rtl/rtc_step_rom.sv
module rtc_step_rom
   import rtc_seq_pkg::*;
#(
   parameter logic [7:0] INIT_SEC  = 8'h30,
   parameter logic [7:0] INIT_MIN  = 8'h11,
   parameter logic [7:0] INIT_HOUR = 8'h08,
   parameter logic [7:0] INIT_DATE = 8'h21,
   parameter logic [7:0] INIT_MON  = 8'h03,
   parameter logic [7:0] INIT_WDAY = 8'h03,
   parameter logic [7:0] INIT_YEAR = 8'h17,
   parameter logic [7:0] TRICKLE   = 8'hA7
) (
   input  logic [STEP_W-1:0] step,
   output logic [BYTE_W-1:0] addr,
   output logic [BYTE_W-1:0] wdata,
   output logic              is_write,
   output logic [IDX_W-1:0]  reg_idx
);
   localparam int unsigned N_INIT = 7;
   localparam logic [N_INIT*BYTE_W-1:0] INIT_PK =
      {INIT_YEAR, INIT_WDAY, INIT_MON, INIT_DATE, INIT_HOUR, INIT_MIN, INIT_SEC};
   localparam logic [STEP_W-1:0] ST_PROT_OFF = STEP_W'(0);
   localparam logic [STEP_W-1:0] ST_LAST_TIME = STEP_W'(N_INIT);
   localparam logic [STEP_W-1:0] ST_TRICKLE = STEP_W'(N_INIT + 1);
   localparam logic [STEP_W-1:0] ST_PROT_ON = STEP_W'(N_INIT + 2);
   localparam logic [STEP_W-1:0] ST_RD0 = STEP_W'(N_WR_STEPS);

   // elaboration checks on the start values
   generate
      for (genvar g = 0; g < N_INIT; g++) begin : g_bcd_chk
         if (INIT_PK[BYTE_W*g +: 4] > 4'd9)
            $error("start value %0d has a non-BCD low digit", g);
         if (g != 0 && INIT_PK[BYTE_W*g+4 +: 4] > 4'd9)
            $error("start value %0d has a non-BCD high digit", g);
      end
      if (INIT_SEC[6:4] > 3'd5) $error("seconds above 59");
      if (INIT_MIN > 8'h59) $error("minutes above 59");
      if (INIT_HOUR > 8'h23) $error("hours must be 24-hour BCD");
      if (INIT_MON == 8'h00 || INIT_MON > 8'h12) $error("month out of range");
      if (INIT_DATE == 8'h00 || INIT_DATE > 8'h31) $error("date out of range");
      if (INIT_WDAY == 8'h00 || INIT_WDAY > 8'h07) $error("weekday out of range");
      if (N_STEPS != N_WR_STEPS + N_RD_STEPS) $error("step count mismatch");
   endgenerate

   logic [IDX_W-1:0] k;
   logic [IDX_W-1:0] r;

   always_comb begin
      addr     = CTRL_ADDR;
      wdata    = PROTECT_OFF;
      is_write = 1'b1;
      reg_idx  = IX_SEC;
      k        = IDX_W'(step - STEP_W'(1));
      r        = IDX_W'(step - ST_RD0);
      if (step == ST_PROT_OFF) begin
         addr  = CTRL_ADDR;
         wdata = PROTECT_OFF;
      end else if (step <= ST_LAST_TIME) begin
         reg_idx = k;
         addr    = {4'h8, k, 1'b0};
         wdata   = INIT_PK[{k, 3'b000} +: BYTE_W];
      end else if (step == ST_TRICKLE) begin
         addr  = TRICKLE_ADDR;
         wdata = TRICKLE;
      end else if (step == ST_PROT_ON) begin
         addr  = CTRL_ADDR;
         wdata = PROTECT_ON;
      end else begin
         is_write = 1'b0;
         wdata    = '0;
         // read order: sec, min, hour, date, month, year, weekday
         if (r == 3'd5)      reg_idx = IX_YEAR;
         else if (r == 3'd6) reg_idx = IX_WDAY;
         else                reg_idx = r;
         addr = {4'h8, reg_idx, 1'b1};
      end
   end
endmodule

// File: rtl/rtc_readback_collect.sv
module rtc_readback_collect
   import rtc_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [IDX_W-1:0]  idx,
   input  logic [BYTE_W-1:0] rdata,
   output logic [WORD_W-1:0] hms_word,
   output logic [WORD_W-1:0] ymd_word,
   output logic [WORD_W-1:0] wday_word
);
   localparam logic [BYTE_W-1:0] HALT_MASK = 8'h7F;

   logic [BYTE_W-1:0] sec_q, min_q, date_q, mon_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q     <= '0;
         min_q     <= '0;
         date_q    <= '0;
         mon_q     <= '0;
         hms_word  <= '0;
         ymd_word  <= '0;
         wday_word <= '0;
      end else if (cap) begin
         case (idx)
            IX_SEC:  sec_q  <= rdata & HALT_MASK;
            IX_MIN:  min_q  <= rdata;
            IX_DATE: date_q <= rdata;
            IX_MON:  mon_q  <= rdata;
            IX_HOUR: hms_word <= {rdata, min_q, sec_q};
            IX_YEAR: ymd_word <= {rdata, mon_q, date_q};
            IX_WDAY: wday_word <= {{(WORD_W-BYTE_W){1'b0}}, rdata};
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rtc_disp_sel.sv
module rtc_disp_sel
   import rtc_seq_pkg::*;
#(
   parameter bit WDAY_FIRST = 1'b1
) (
   input  logic [1:0]        key,
   input  logic [WORD_W-1:0] hms_word,
   input  logic [WORD_W-1:0] ymd_word,
   input  logic [WORD_W-1:0] wday_word,
   output logic [WORD_W-1:0] disp_word
);
   generate
      if (WDAY_FIRST) begin : g_wday_first
         always_comb begin
            if (key[0])      disp_word = wday_word;
            else if (key[1]) disp_word = ymd_word;
            else             disp_word = hms_word;
         end
      end else begin : g_date_first
         always_comb begin
            if (key[1])      disp_word = ymd_word;
            else if (key[0]) disp_word = wday_word;
            else             disp_word = hms_word;
         end
      end
   endgenerate
endmodule

// File: rtl/rtc_init_poll_seq.sv
module rtc_init_poll_seq
   import rtc_seq_pkg::*;
#(
   parameter logic [7:0] INIT_SEC   = 8'h30,
   parameter logic [7:0] INIT_MIN   = 8'h11,
   parameter logic [7:0] INIT_HOUR  = 8'h08,
   parameter logic [7:0] INIT_DATE  = 8'h21,
   parameter logic [7:0] INIT_MON   = 8'h03,
   parameter logic [7:0] INIT_WDAY  = 8'h03,
   parameter logic [7:0] INIT_YEAR  = 8'h17,
   parameter logic [7:0] TRICKLE    = 8'hA7,
   parameter bit         WDAY_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic        xfer_req,
   output logic        xfer_write,
   output logic [7:0]  xfer_addr,
   output logic [7:0]  xfer_wdata,
   input  logic        xfer_done,
   input  logic [7:0]  xfer_rdata,
   input  logic [1:0]  key,
   output logic [23:0] disp_word
);
   localparam logic [STEP_W-1:0] FIRST_RD = STEP_W'(N_WR_STEPS);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

   sq_state_t         state;
   logic [STEP_W-1:0] step;
   logic              busy;
   logic              cap;
   logic [IDX_W-1:0]  reg_idx;
   logic              is_write;
   logic [WORD_W-1:0] hms_word, ymd_word, wday_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         step  <= '0;
      end else begin
         case (state)
            SQ_IDLE:  state <= SQ_ISSUE;
            SQ_ISSUE: state <= SQ_WAIT;
            SQ_WAIT: if (xfer_done) begin
               state <= SQ_ISSUE;
               step  <= (step == LAST_STEP) ? FIRST_RD : step + STEP_W'(1);
            end
            default:  state <= SQ_IDLE;
         endcase
      end
   end

   assign busy     = (state == SQ_WAIT);
   assign xfer_req = (state == SQ_ISSUE);
   assign cap      = busy & xfer_done & ~is_write;
   assign xfer_write = is_write;

   rtc_step_rom #(
      .INIT_SEC (INIT_SEC),  .INIT_MIN (INIT_MIN),  .INIT_HOUR(INIT_HOUR),
      .INIT_DATE(INIT_DATE), .INIT_MON (INIT_MON),  .INIT_WDAY(INIT_WDAY),
      .INIT_YEAR(INIT_YEAR), .TRICKLE  (TRICKLE)
   ) u_rom (
      .step    (step),
      .addr    (xfer_addr),
      .wdata   (xfer_wdata),
      .is_write(is_write),
      .reg_idx (reg_idx)
   );

   rtc_readback_collect u_collect (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (cap),
      .idx      (reg_idx),
      .rdata    (xfer_rdata),
      .hms_word (hms_word),
      .ymd_word (ymd_word),
      .wday_word(wday_word)
   );

   rtc_disp_sel #(.WDAY_FIRST(WDAY_FIRST)) u_sel (
      .key      (key),
      .hms_word (hms_word),
      .ymd_word (ymd_word),
      .wday_word(wday_word),
      .disp_word(disp_word)
   );
endmodule

// File: rtl/rtc_seq_chk.sv
module rtc_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        xfer_req,
   input logic        xfer_write,
   input logic [7:0]  xfer_addr,
   input logic [7:0]  xfer_wdata,
   input logic        xfer_done,
   input logic        busy,
   input logic [23:0] hms_word
);
   logic protect_seen;
   logic first_pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         protect_seen  <= 1'b0;
         first_pending <= 1'b1;
      end else if (busy && xfer_done) begin
         first_pending <= 1'b0;
         if (xfer_write && xfer_addr == 8'h8E && xfer_wdata == 8'h80)
            protect_seen <= 1'b1;
      end
   end

   a_r1_first_write: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && first_pending) |-> (xfer_write && xfer_addr == 8'h8E && xfer_wdata == 8'h00));

   a_r2_write_addr_even: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && xfer_write) |-> !xfer_addr[0]);

   a_r4_read_after_protect: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_write) |-> protect_seen);

   a_r5_read_addr_odd: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_write) |-> xfer_addr[0]);

   a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |=> !xfer_req);

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !xfer_done) |=> ($stable(xfer_addr) && $stable(xfer_wdata)
                                && $stable(xfer_write) && !xfer_req));

   a_r7_hms_after_hour: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hms_word) |-> $past(busy && xfer_done && !xfer_write && xfer_addr == 8'h85));
endmodule

bind rtc_init_poll_seq rtc_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .xfer_req  (xfer_req),
   .xfer_write(xfer_write),
   .xfer_addr (xfer_addr),
   .xfer_wdata(xfer_wdata),
   .xfer_done (xfer_done),
   .busy      (busy),
   .hms_word  (hms_word)
);

// File: tb/tb_rtc_init_poll_seq.sv
module tb_rtc_init_poll_seq;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_req, xfer_write;
   logic [7:0]  xfer_addr, xfer_wdata;
   logic        xfer_done = 1'b0;
   logic [7:0]  xfer_rdata = 8'h00;
   logic [1:0]  key = 2'b00;
   logic [23:0] disp_word;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   bit finished = 0;

   // expected step table from R1-style requirement list (addr, data, write)
   logic [7:0] exp_addr [17];
   logic [7:0] exp_data [17];

   // bench model of display words
   logic [7:0]  m_sec, m_min, m_date, m_mon;
   logic [23:0] m_hms, m_ymd, m_wday;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_init_poll_seq dut (
      .clk(clk), .rst_n(rst_n),
      .xfer_req(xfer_req), .xfer_write(xfer_write),
      .xfer_addr(xfer_addr), .xfer_wdata(xfer_wdata),
      .xfer_done(xfer_done), .xfer_rdata(xfer_rdata),
      .key(key), .disp_word(disp_word)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !finished) begin
         finished = 1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
         summary();
      end
   end

   function automatic logic [7:0] rd_val(input int lp, input int idx);
      int v;
      logic [7:0] b;
      v = (lp * 13 + idx * 7 + 5) % 60;
      b = 8'((v / 10) * 16 + (v % 10));
      if (idx == 0 && (lp % 2) == 1) b = b | 8'h80;
      return b;
   endfunction

   function automatic int step_of(input int tn);
      return (tn < 10) ? tn : 10 + ((tn - 10) % 7);
   endfunction

   task automatic check_keys();
      key = 2'b00; #1;
      chk(disp_word === m_hms, "R10/R7 key=00 time word", disp_word, m_hms);
      key = 2'b01; #1;
      chk(disp_word === m_wday, "R10/R9 key=01 weekday word", disp_word, m_wday);
      key = 2'b10; #1;
      chk(disp_word === m_ymd, "R10/R8 key=10 date word", disp_word, m_ymd);
      key = 2'b11; #1;
      chk(disp_word === m_wday, "R10 key=11 weekday word", disp_word, m_wday);
      key = 2'b00;
   endtask

   // one transaction served by the bench acting as engine
   task automatic serve(input int tn, input int lp);
      int st;
      int guard;
      int lat;
      logic [7:0] a0, d0, rb;
      logic       w0;
      st = step_of(tn);
      guard = 0;
      while (!xfer_req && guard < 20) begin
         @(negedge clk);
         guard++;
      end
      chk(xfer_req === 1'b1, "R6 request arrives", {31'd0, xfer_req}, 32'd1);
      a0 = xfer_addr; d0 = xfer_wdata; w0 = xfer_write;
      chk(xfer_addr === exp_addr[st],
          (st == 0) ? "R1 addr" : (st < 8) ? "R2 addr" : (st == 8) ? "R3 addr" :
          (st == 9) ? "R4 addr" : "R5 addr", xfer_addr, exp_addr[st]);
      chk(xfer_write === (st < 10), "R5 direction", {31'd0, xfer_write}, {31'd0, (st < 10)});
      if (st < 10)
         chk(xfer_wdata === exp_data[st],
             (st == 0) ? "R1 data" : (st < 8) ? "R2 data" : (st == 8) ? "R3 data" : "R4 data",
             xfer_wdata, exp_data[st]);
      lat = 1 + (tn % 4);
      for (int c = 0; c < lat; c++) begin
         @(negedge clk);
         chk(xfer_req === 1'b0, "R6 no request while pending", {31'd0, xfer_req}, 32'd0);
         chk(xfer_addr === a0 && xfer_wdata === d0 && xfer_write === w0,
             "R6 fields stable", {xfer_addr, xfer_wdata}, {a0, d0});
      end
      rb = 8'h00;
      if (st >= 10) begin
         case (st - 10)
            0: rb = rd_val(lp, 0);
            1: rb = rd_val(lp, 1);
            2: rb = rd_val(lp, 2);
            3: rb = rd_val(lp, 3);
            4: rb = rd_val(lp, 4);
            5: rb = rd_val(lp, 6);
            default: rb = 8'(1 + (lp % 7));
         endcase
      end
      xfer_rdata = rb;
      xfer_done  = 1'b1;
      @(negedge clk);
      xfer_done  = 1'b0;
      xfer_rdata = 8'h00;
      if (st >= 10) begin
         case (st - 10)
            0: m_sec  = rb & 8'h7F;
            1: m_min  = rb;
            2: m_hms  = {rb, m_min, m_sec};
            3: m_date = rb;
            4: m_mon  = rb;
            5: m_ymd  = {rb, m_mon, m_date};
            default: m_wday = {16'h0000, rb};
         endcase
         check_keys();
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(xfer_req === 1'b0, "R11 no request in reset", {31'd0, xfer_req}, 32'd0);
      for (int k = 0; k < 4; k++) begin
         key = 2'(k); #1;
         chk(disp_word === 24'h0, "R11 display cleared", disp_word, 24'h0);
      end
      key = 2'b00;
      m_sec = 0; m_min = 0; m_date = 0; m_mon = 0;
      m_hms = 0; m_ymd = 0; m_wday = 0;
      rst_n = 1'b1;
   endtask

   initial begin
      exp_addr[0]  = 8'h8E; exp_data[0]  = 8'h00;
      exp_addr[1]  = 8'h80; exp_data[1]  = 8'h30;
      exp_addr[2]  = 8'h82; exp_data[2]  = 8'h11;
      exp_addr[3]  = 8'h84; exp_data[3]  = 8'h08;
      exp_addr[4]  = 8'h86; exp_data[4]  = 8'h21;
      exp_addr[5]  = 8'h88; exp_data[5]  = 8'h03;
      exp_addr[6]  = 8'h8A; exp_data[6]  = 8'h03;
      exp_addr[7]  = 8'h8C; exp_data[7]  = 8'h17;
      exp_addr[8]  = 8'h90; exp_data[8]  = 8'hA7;
      exp_addr[9]  = 8'h8E; exp_data[9]  = 8'h80;
      exp_addr[10] = 8'h81; exp_addr[11] = 8'h83; exp_addr[12] = 8'h85;
      exp_addr[13] = 8'h87; exp_addr[14] = 8'h89; exp_addr[15] = 8'h8D;
      exp_addr[16] = 8'h8B;
      for (int i = 10; i < 17; i++) exp_data[i] = 8'h00;

      @(negedge clk);
      do_reset();
      // full run: writes, then four read loops
      for (int tn = 0; tn < 10 + 4 * 7; tn++)
         serve(tn, (tn < 10) ? 0 : (tn - 10) / 7);
      // partial loop, then reset mid-sequence (R11)
      for (int tn = 38; tn < 42; tn++) serve(tn, 4);
      do_reset();
      for (int tn = 0; tn < 10 + 2 * 7; tn++)
         serve(tn, (tn < 10) ? 5 : 5 + (tn - 10) / 7);
      finished = 1;
      summary();
   end
endmodule